// File: doc/BRIEF.md
# Sequential Byte/Word Reader over a Cached Quad Block

The block keeps one 16-byte data block, captured in a single load as four 32-bit longs. Successive read strobes then walk through that block one byte or one 16-bit halfword at a time. An internal 4-bit offset counter tracks the position. The caller never supplies an address, so a loop that unpacks a fetched block needs one command per element and no pointer arithmetic.

Each read places its element, zero-extended, on a 32-bit result register in the cycle after the strobe. A carry flag marks the element that finishes the block. The counter then wraps back to zero, so the same block can be walked again without reloading it.

Top module: `qbr_reader`

## Requirements
- R1: While reset is asserted and after it is released, `result_o` is 0, `carry_o` is 0 and the internal offset is 0.
- R2: A load stores all 128 bits of `load_data_i` and sets the offset to 0. On the next clock edge `result_o` and `carry_o` both become 0.
- R3: A byte read returns byte k of the block, where k is the current offset. Byte k occupies bits 8k+7:8k of `load_data_i`, so byte 0 is bits 7:0 of long 0. The value appears zero-extended on `result_o` one cycle after the strobe, and the offset then increases by 1.
- R4: A word read returns byte k in result bits 7:0 and byte k+1 (modulo 16) in bits 15:8, where k is the current offset. Bits 31:16 are zero. The offset then increases by 2.
- R5: `carry_o` goes to 1 after a byte read at offset 15, or after a word read at offset 14 or 15. After any other read it goes to 0.
- R6: The offset advances modulo 16, so reads continue from byte 0 after a wrap without a new load.
- R7: When a load and any read are strobed in the same cycle, only the load takes effect.
- R8: When the byte and word strobes are both high without a load, only the byte read takes effect.
- R9: In a cycle with no strobe, `result_o`, `carry_o` and the offset keep their values.
- R10: A word read at an odd offset is defined behaviour. At offset 15 it returns byte 15 low and byte 0 high, and leaves the offset at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture `load_data_i` and clear the offset |
| load_data_i | input | 128 | Four longs; long n in bits 32n+31:32n |
| rd_byte_i | input | 1 | Read the byte at the offset, advance by 1 |
| rd_word_i | input | 1 | Read the halfword at the offset, advance by 2 |
| result_o | output | 32 | Zero-extended element from the latest read |
| carry_o | output | 1 | High when the latest read completed the block |

## Verification
The bench compares every cycle against a behavioural model. It aims at the cases below:
- **Block boundary.** The carry must rise on the sixteenth byte or the eighth word. A counter that is off by one flags the wrong element. A counter that saturates instead of wrapping repeats the last byte.
- **Re-walking after a wrap.** A design that fails to wrap returns stale data when the block is read again.
- **Colliding strobes.** When a load collides with a read, a design with the wrong priority leaks block data onto `result_o`. When both read strobes are high, such a design advances the offset by 2.
- **Odd word offsets.** A design that indexes past the block on a word read at offset 15 returns garbage in the upper byte.
- **Idle cycles.** Any spurious update during idle cycles shows up as a changed result.

// File: rtl/qbr_pkg.sv
package qbr_pkg;

   typedef enum logic [1:0] {
      QBR_IDLE = 2'd0,
      QBR_LOAD = 2'd1,
      QBR_BYTE = 2'd2,
      QBR_WORD = 2'd3
   } qbr_op_e;

   // Load outranks byte read, byte read outranks word read.
   function automatic qbr_op_e qbr_decode(input logic ld, input logic rb, input logic rw);
      if (ld)      return QBR_LOAD;
      else if (rb) return QBR_BYTE;
      else if (rw) return QBR_WORD;
      else         return QBR_IDLE;
   endfunction

endpackage

// File: rtl/qbr_store.sv
module qbr_store #(
   parameter int DATA_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
   end
endmodule

// File: rtl/qbr_offset.sv
module qbr_offset #(
   parameter int OFF_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step_byte,
   input  logic             step_word,
   output logic [OFF_W-1:0] off_o,
   output logic             wrap_o
);
   logic [OFF_W:0] incr;
   logic [OFF_W:0] sum;

   always_comb begin
      if (step_byte)      incr = (OFF_W+1)'(1);
      else if (step_word) incr = (OFF_W+1)'(2);
      else                incr = '0;
      sum    = {1'b0, off_o} + incr;
      wrap_o = sum[OFF_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      off_o <= '0;
      else if (clr)                    off_o <= '0;
      else if (step_byte || step_word) off_o <= sum[OFF_W-1:0];
   end
endmodule

// File: rtl/qbr_extract.sv
module qbr_extract #(
   parameter int BYTES = 16,
   parameter int OFF_W = 4
) (
   input  logic [BYTES*8-1:0] block,
   input  logic [OFF_W-1:0]   off,
   output logic [7:0]         byte_o,
   output logic [15:0]        word_o
);
   logic [7:0]       lane [BYTES];
   logic [OFF_W-1:0] off_nx;

   for (genvar g = 0; g < BYTES; g++) begin : g_lane
      assign lane[g] = block[g*8 +: 8];
   end

   assign off_nx = off + OFF_W'(1);
   assign byte_o = lane[off];
   assign word_o = {lane[off_nx], lane[off]};
endmodule

// File: rtl/qbr_reader.sv
module qbr_reader
   import qbr_pkg::*;
#(
   parameter int LONG_W = 32,
   parameter int LONGS  = 4,
   parameter int RES_W  = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load_i,
   input  logic [LONGS*LONG_W-1:0] load_data_i,
   input  logic                    rd_byte_i,
   input  logic                    rd_word_i,
   output logic [RES_W-1:0]        result_o,
   output logic                    carry_o
);
   localparam int DATA_W = LONGS * LONG_W;
   localparam int BYTES  = DATA_W / 8;
   localparam int OFF_W  = $clog2(BYTES);

   if (LONG_W % 8 != 0) begin : g_bad_long
      $error("qbr_reader: LONG_W must be a whole number of bytes");
   end
   if ((BYTES & (BYTES - 1)) != 0 || BYTES < 2) begin : g_bad_bytes
      $error("qbr_reader: block byte count must be a power of two");
   end
   if (RES_W < 16) begin : g_bad_res
      $error("qbr_reader: RES_W must hold a halfword");
   end

   qbr_op_e          op;
   logic [DATA_W-1:0] blk;
   logic [OFF_W-1:0]  off;
   logic              wrap;
   logic [7:0]        sel_byte;
   logic [15:0]       sel_word;

   assign op = qbr_decode(load_i, rd_byte_i, rd_word_i);

   qbr_store #(.DATA_W(DATA_W)) u_store (
      .clk (clk),
      .rst_n (rst_n),
      .we (op == QBR_LOAD),
      .d (load_data_i),
      .q (blk)
   );

   qbr_offset #(.OFF_W(OFF_W)) u_offset (
      .clk (clk),
      .rst_n (rst_n),
      .clr (op == QBR_LOAD),
      .step_byte (op == QBR_BYTE),
      .step_word (op == QBR_WORD),
      .off_o (off),
      .wrap_o (wrap)
   );

   qbr_extract #(.BYTES(BYTES), .OFF_W(OFF_W)) u_extract (
      .block (blk),
      .off (off),
      .byte_o (sel_byte),
      .word_o (sel_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o <= '0;
         carry_o  <= 1'b0;
      end else begin
         unique case (op)
            QBR_LOAD: begin
               result_o <= '0;
               carry_o  <= 1'b0;
            end
            QBR_BYTE: begin
               result_o <= RES_W'(sel_byte);
               carry_o  <= wrap;
            end
            QBR_WORD: begin
               result_o <= RES_W'(sel_word);
               carry_o  <= wrap;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/qbr_reader_chk.sv
module qbr_reader_chk #(
   parameter int RES_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load_i,
   input logic             rd_byte_i,
   input logic             rd_word_i,
   input logic [RES_W-1:0] result_o,
   input logic             carry_o
);
   logic [3:0] chk_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         chk_off <= '0;
      else if (load_i)    chk_off <= '0;
      else if (rd_byte_i) chk_off <= chk_off + 4'd1;
      else if (rd_word_i) chk_off <= chk_off + 4'd2;
   end

   AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (result_o == '0) && !carry_o); // R2

   AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_byte_i && !load_i) |=> (result_o[RES_W-1:8] == '0)); // R3

   AST_WORD_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_word_i && !rd_byte_i && !load_i) |=> (result_o[RES_W-1:16] == '0)); // R4

   AST_BYTE_LAST_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_byte_i && !load_i && chk_off == 4'hF) |=> carry_o); // R5

   AST_BYTE_MID_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_byte_i && !load_i && chk_off != 4'hF) |=> !carry_o); // R5

   AST_WORD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_word_i && !rd_byte_i && !load_i) |=> (carry_o == $past(chk_off >= 4'hE))); // R5

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && (rd_byte_i || rd_word_i)) |=> (result_o == '0)); // R7

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !rd_byte_i && !rd_word_i) |=> ($stable(result_o) && $stable(carry_o))); // R9
endmodule

bind qbr_reader qbr_reader_chk #(.RES_W(RES_W)) u_chk (
   .clk (clk),
   .rst_n (rst_n),
   .load_i (load_i),
   .rd_byte_i (rd_byte_i),
   .rd_word_i (rd_word_i),
   .result_o (result_o),
   .carry_o (carry_o)
);

// File: tb/qbr_reader_bench.sv
module qbr_reader_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         load_i = 1'b0;
   logic [127:0] load_data_i = '0;
   logic         rd_byte_i = 1'b0;
   logic         rd_word_i = 1'b0;
   logic [31:0]  result_o;
   logic         carry_o;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 0;

   // Reference model state
   logic [7:0]  m_mem [16];
   int          m_off = 0;
   logic [31:0] m_res = '0;
   logic        m_car = 1'b0;
   string       cur_tag = "R1";
   string       exp_tag = "R1";

   always #5 clk = ~clk;

   qbr_reader u_qbr_reader (
      .clk (clk),
      .rst_n (rst_n),
      .load_i (load_i),
      .load_data_i (load_data_i),
      .rd_byte_i (rd_byte_i),
      .rd_word_i (rd_word_i),
      .result_o (result_o),
      .carry_o (carry_o)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_off = 0;
         m_res = '0;
         m_car = 1'b0;
         for (int i = 0; i < 16; i++) m_mem[i] = 8'h00;
      end else begin
         exp_tag = cur_tag;
         if (load_i) begin
            for (int i = 0; i < 16; i++) m_mem[i] = load_data_i[i*8 +: 8];
            m_off = 0;
            m_res = '0;
            m_car = 1'b0;
         end else if (rd_byte_i) begin
            m_res = {24'h0, m_mem[m_off]};
            m_car = (m_off == 15);
            m_off = (m_off + 1) % 16;
         end else if (rd_word_i) begin
            m_res = {16'h0, m_mem[(m_off + 1) % 16], m_mem[m_off]};
            m_car = (m_off >= 14);
            m_off = (m_off + 2) % 16;
         end
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         cycles++;
         checks++;
         if (result_o !== m_res || carry_o !== m_car) begin
            failures++;
            $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                     exp_tag, result_o, carry_o, m_res, m_car);
         end
         if (cycles > 5000) begin
            failures++;
            $display("FAIL watchdog: cycles=%0d expected completion", cycles);
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   task automatic step(input bit ld, input bit rb, input bit rw, input string tag);
      @(negedge clk);
      load_i    = ld;
      rd_byte_i = rb;
      rd_word_i = rw;
      cur_tag   = tag;
      if (ld) load_data_i = {$urandom, $urandom, $urandom, $urandom};
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;          // R1: compare of reset values happens above
      step(0, 0, 0, "R1");

      // Byte walk of a full block, then wrap
      step(1, 0, 0, "R2");
      for (int i = 0; i < 15; i++) step(0, 1, 0, "R3");
      step(0, 1, 0, "R5");   // last byte raises carry
      for (int i = 0; i < 4; i++) step(0, 1, 0, "R6");

      // Word walk, then wrap
      step(1, 0, 0, "R2");
      for (int i = 0; i < 7; i++) step(0, 0, 1, "R4");
      step(0, 0, 1, "R5");
      step(0, 0, 1, "R6");

      // Idle holds
      for (int i = 0; i < 3; i++) step(0, 0, 0, "R9");

      // Load colliding with reads
      step(1, 1, 0, "R7");
      step(1, 0, 1, "R7");
      step(0, 1, 0, "R7");

      // Both read strobes
      step(0, 1, 1, "R8");
      step(0, 1, 1, "R8");
      step(0, 0, 1, "R8");

      // Odd-offset word reads across the end
      step(1, 0, 0, "R2");
      for (int i = 0; i < 15; i++) step(0, 1, 0, "R3");
      step(0, 0, 1, "R10");  // offset 15: byte 15 low, byte 0 high
      step(0, 1, 0, "R10");  // offset now 1
      step(0, 0, 1, "R10");

      // Mixed random traffic
      for (int i = 0; i < 300; i++) begin
         int r = $urandom % 8;
         step(r == 0, r inside {1, 2, 3, 6}, r inside {4, 5, 6}, "R6");
      end
      step(0, 0, 0, "R9");
      @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule